// File: doc/BRIEF.md
# Bi-phase Serial Word Receiver with CRC Check

This block takes an oversampled serial line carrying bi-phase-mark coded words and turns each error-free word into a parallel payload with a one-cycle load strobe. The line is sampled eight times per bit. Every bit boundary carries a transition. A one is marked by an extra transition in the middle of the bit. Each word opens with a sync bit of double length, followed by 59 coded bits: a 43-bit payload and a 16-bit CRC.

A word that fails its CRC, stops early or breaks the coding rules is thrown away whole. Such a word raises the local (uplink) error flag. A good word whose top payload bit is set raises a second (downlink) flag, which carries an error reported by the far end. A single read strobe returns and clears both flags.

A tick-driven watchdog tracks link liveness. The link-valid bit drops 120 ticks after the last good word and the data-valid bit drops after 66 ticks. While the link is not valid the payload output reads zero.

Top module: `biphase_frame_rx`

## Requirements
- R1: A word starts when two line transitions are 12 to 20 samples apart. This sync may also interrupt a word in progress and restart it. The 59 bits that follow are received in order, and the first one becomes payload bit 42 (the most significant).
- R2: Within a word, one interval of 6 to 10 samples decodes as a 0, and two consecutive intervals of 2 to 5 samples decode as a 1.
- R3: The CRC uses polynomial 0x1021 with a preset of 0xFFFF. It runs MSB first over the 43 payload bits, and the 16 check bits follow MSB first. For a good word, `load` is high for exactly one cycle and `payload` takes the new value. Both are visible after the third rising clock edge following the word's final transition at `line_in`.
- R4: On a CRC mismatch there is no load and `payload` keeps its old value. `up_err` is set, with the same timing as R3.
- R5: A word is discarded and `up_err` is set in any of these cases: no transition for 21 samples while inside a word, an interval that fits no class, or a new sync arriving before the word is complete.
- R6: A good word with payload bit 42 set sets `dn_err`.
- R7: `rd_clr` clears both flags at the next clock edge. A flag set in the same cycle wins over the clear.
- R8: `link_ok` is 1 from a good word until 120 `tick` pulses have followed it. While `link_ok` is 0, `payload` reads 0.
- R9: `adc_ok` is 1 from a good word until 66 `tick` pulses have followed it.
- R10: After reset all outputs are 0 and stay 0 until the first good word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Serial line |
| rd_clr | input | 1 | Read strobe that clears both flags |
| tick | input | 1 | Timebase pulse for the watchdog |
| payload | output | 43 | Last good payload, 0 when link down |
| load | output | 1 | One-cycle strobe for a good word |
| up_err | output | 1 | Local receive error flag |
| dn_err | output | 1 | Remote-reported error flag |
| link_ok | output | 1 | Link alive |
| adc_ok | output | 1 | Data fresh |

## Verification
The hardest case to reach is a word cut short by a fresh sync in the middle of a word. Only an exact interval sequence on the line can produce it. The bench sends a sync and ten bits, then goes straight into a complete word, so the new sync's double gap lands inside the old word. The bench then expects both an error and a load of the new word. A second hard case is a flag being set in the same cycle as it is cleared. The bench times `rd_clr` to coincide with the registration of a failed CRC.

// File: rtl/biphase_frame_rx.sv
module biphase_frame_rx #(
  parameter int OVS       = 8,
  parameter int WORD_BITS = 60,
  parameter int CRC_W     = 16,
  parameter int LINK_TO   = 120,
  parameter int ADC_TO    = 66
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                line_in,
  input  logic                                rd_clr,
  input  logic                                tick,
  output logic [WORD_BITS-CRC_W-2:0]          payload,
  output logic                                load,
  output logic                                up_err,
  output logic                                dn_err,
  output logic                                link_ok,
  output logic                                adc_ok
);
  localparam int DBITS   = WORD_BITS - 1;
  localparam int PAY_W   = DBITS - CRC_W;
  localparam int HALF_LO = OVS / 4;
  localparam int HALF_HI = OVS / 2 + OVS / 8;
  localparam int FULL_LO = OVS - OVS / 4;
  localparam int FULL_HI = OVS + OVS / 4;
  localparam int SYNC_LO = 2 * OVS - OVS / 2;
  localparam int SYNC_HI = 2 * OVS + OVS / 2;
  localparam int STALE   = SYNC_HI + 1;
  localparam int CW      = $clog2(STALE + 2);
  localparam int BW      = $clog2(DBITS + 1);
  localparam int TW      = $clog2(LINK_TO + 1);
  localparam logic [CRC_W-1:0] POLY = 16'h1021;

  logic s1, s2, s3;
  logic [CW-1:0] cnt;
  logic in_frame, half;
  logic [BW-1:0] bidx;
  logic [CRC_W-1:0] crc, crc_nx;
  logic [DBITS-2:0] sreg;
  logic [DBITS-1:0] word;
  logic [PAY_W-1:0] pay_q;
  logic [TW-1:0] tcnt;
  logic seen;
  logic edge_w, is_half, is_full, is_sync;
  logic shift_ev, bit_val, abort, restart, last, good, bad, up_set, dn_set;

  assign edge_w  = s2 ^ s3;
  assign is_half = cnt >= CW'(HALF_LO) && cnt <= CW'(HALF_HI);
  assign is_full = cnt >= CW'(FULL_LO) && cnt <= CW'(FULL_HI);
  assign is_sync = cnt >= CW'(SYNC_LO) && cnt <= CW'(SYNC_HI);

  always_comb begin
    shift_ev = 1'b0;
    bit_val  = 1'b0;
    abort    = 1'b0;
    restart  = 1'b0;
    if (edge_w) begin
      if (is_sync) begin
        restart = 1'b1;
        abort   = in_frame;
      end else if (in_frame) begin
        if (is_full && !half) shift_ev = 1'b1;
        else if (is_half && half) begin
          shift_ev = 1'b1;
          bit_val  = 1'b1;
        end else if (!(is_half && !half)) abort = 1'b1;
      end
    end else if (in_frame && cnt == CW'(STALE)) abort = 1'b1;
  end

  assign crc_nx = {crc[CRC_W-2:0], 1'b0} ^ ((crc[CRC_W-1] ^ bit_val) ? POLY : '0);
  assign word   = {sreg, bit_val};
  assign last   = shift_ev && bidx == BW'(DBITS - 1);
  assign good   = last && crc_nx == '0;
  assign bad    = last && crc_nx != '0;
  assign up_set = bad || abort;
  assign dn_set = good && word[DBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      cnt <= '1;
      in_frame <= 1'b0; half <= 1'b0; bidx <= '0;
      crc <= '1; sreg <= '0; pay_q <= '0;
      load <= 1'b0; up_err <= 1'b0; dn_err <= 1'b0;
      tcnt <= '0; seen <= 1'b0;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
      if (edge_w) cnt <= CW'(1);
      else if (cnt != '1) cnt <= cnt + 1'b1;
      if (restart) begin
        in_frame <= 1'b1; half <= 1'b0; bidx <= '0; crc <= '1;
      end else if (abort) begin
        in_frame <= 1'b0;
      end else if (in_frame && edge_w) begin
        if (shift_ev) begin
          half <= 1'b0;
          sreg <= word[DBITS-2:0];
          crc  <= crc_nx;
          bidx <= bidx + 1'b1;
          if (last) in_frame <= 1'b0;
        end else half <= 1'b1;
      end
      load <= good;
      if (good) pay_q <= word[DBITS-1:CRC_W];
      up_err <= (up_err && !rd_clr) || up_set;
      dn_err <= (dn_err && !rd_clr) || dn_set;
      if (good) begin
        tcnt <= '0; seen <= 1'b1;
      end else if (tick && tcnt != TW'(LINK_TO)) tcnt <= tcnt + 1'b1;
    end
  end

  assign link_ok = seen && tcnt < TW'(LINK_TO);
  assign adc_ok  = seen && tcnt < TW'(ADC_TO);
  assign payload = link_ok ? pay_q : '0;

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n) load |=> !load);
  p_load_link_r8:  assert property (@(posedge clk) disable iff (!rst_n) load |-> link_ok && adc_ok);
  p_crc_bad_r4:    assert property (@(posedge clk) disable iff (!rst_n) bad |=> up_err && !load);
  p_abort_r5:      assert property (@(posedge clk) disable iff (!rst_n) abort |=> up_err);
  p_remote_r6:     assert property (@(posedge clk) disable iff (!rst_n) dn_set |=> dn_err);
  p_clear_r7:      assert property (@(posedge clk) disable iff (!rst_n) (rd_clr && !up_set) |=> !up_err);
  p_fresh_r9:      assert property (@(posedge clk) disable iff (!rst_n) adc_ok |-> link_ok);
endmodule

// File: tb/sim_biphase_frame_rx.sv
`timescale 1ns/1ps
module sim_biphase_frame_rx;
  localparam int LINK_TO = 120;
  localparam int ADC_TO  = 66;
  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b0, rd_clr = 1'b0, tick = 1'b0;
  logic [42:0] payload;
  logic load, up_err, dn_err, link_ok, adc_ok;
  int compared = 0, mismatched = 0;

  biphase_frame_rx u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .rd_clr(rd_clr), .tick(tick),
    .payload(payload), .load(load), .up_err(up_err), .dn_err(dn_err), .link_ok(link_ok), .adc_ok(adc_ok));

  always #2.5 clk = ~clk;

  // reference model state
  bit exp_load, exp_up, exp_dn, seen, mask_up, ev_good;
  logic [42:0] exp_pq, ev_pay;
  int tcnt, pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_load = 0; exp_up = 0; exp_dn = 0; seen = 0; exp_pq = '0; tcnt = 0; pend = 0;
    end else begin
      exp_load = 0;
      if (rd_clr) begin exp_up = 0; exp_dn = 0; end
      if (tick && tcnt < LINK_TO) tcnt++;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (ev_good) begin
            exp_load = 1; exp_pq = ev_pay; seen = 1; tcnt = 0;
            if (ev_pay[42]) exp_dn = 1;
          end else exp_up = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit el, ea;
    el = seen && tcnt < LINK_TO;
    ea = seen && tcnt < ADC_TO;
    chk(load === exp_load, "R3 load", 64'(load), 64'(exp_load));
    chk(payload === (el ? exp_pq : 43'd0), "R8 payload", 64'(payload), 64'(el ? exp_pq : 43'd0));
    if (!mask_up) chk(up_err === exp_up, "R4 up_err", 64'(up_err), 64'(exp_up));
    chk(dn_err === exp_dn, "R6 dn_err", 64'(dn_err), 64'(exp_dn));
    chk(link_ok === el, "R8 link_ok", 64'(link_ok), 64'(el));
    chk(adc_ok === ea, "R9 adc_ok", 64'(adc_ok), 64'(ea));
  end

  function automatic logic [15:0] crc_of(input logic [42:0] p);
    logic [15:0] c = 16'hFFFF;
    for (int i = 42; i >= 0; i--) begin
      bit fb = c[15] ^ p[i];
      c = {c[14:0], 1'b0};
      if (fb) c ^= 16'h1021;
    end
    return c;
  endfunction

  task automatic seg(input int n);
    @(posedge clk); #1 line_in = ~line_in;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic bitseg(input bit b);
    if (b) begin seg(4); seg(4); end
    else seg(8);
  endtask

  // cut > 0: stop after that many coded bits
  task automatic send(input logic [42:0] p, input bit badcrc, input int cut, input bit clr_last);
    logic [15:0] c;
    logic [58:0] w;
    int n;
    c = crc_of(p);
    if (badcrc) c ^= 16'h0001;
    w = {p, c};
    if (cut > 0) mask_up = 1;
    seg(16);
    n = (cut > 0) ? cut : 59;
    for (int i = 0; i < n; i++) bitseg(w[58 - i]);
    if (cut == 0) begin
      @(posedge clk); #1 line_in = ~line_in;
      ev_good = !badcrc; ev_pay = p; pend = 3;
      if (clr_last) begin
        @(posedge clk); @(posedge clk); #1 rd_clr = 1;
        @(posedge clk); #1 rd_clr = 0;
      end
    end
    repeat (40) @(posedge clk);
    if (cut > 0) begin #1 exp_up = 1; mask_up = 0; end
  endtask

  task automatic pulse_clr;
    @(posedge clk); #1 rd_clr = 1;
    @(posedge clk); #1 rd_clr = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(posedge clk); #1 tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (40) @(negedge clk);
    chk(payload === 0 && !link_ok && !adc_ok && !up_err && !dn_err && !load, "R10 reset",
        64'({payload, link_ok, adc_ok}), 64'd0);
    send(43'h123_4567_89AB, 0, 0, 0);
    @(negedge clk); chk(payload === 43'h123_4567_89AB, "R1 word order", 64'(payload), 64'h123_4567_89AB);
    send(43'h7FF_FFFF_FFFF, 0, 0, 0);
    @(negedge clk); chk(payload === 43'h7FF_FFFF_FFFF && dn_err, "R2 all ones and R6", 64'(payload), 64'h7FF_FFFF_FFFF);
    pulse_clr();
    @(negedge clk); chk(!dn_err && !up_err, "R7 clear", 64'({dn_err, up_err}), 64'd0);
    send(43'h000_0000_0000, 0, 0, 0);
    send(43'h2AA_5555_0F0F, 1, 0, 0);
    @(negedge clk); chk(payload === 43'd0 && up_err, "R4 discard", 64'(payload), 64'd0);
    pulse_clr();
    send(43'h155_AAAA_F0F0, 0, 20, 0);
    @(negedge clk); chk(up_err && payload === 43'd0, "R5 short word", 64'(up_err), 64'd1);
    pulse_clr();
    mask_up = 1;
    seg(16);
    for (int i = 0; i < 10; i++) bitseg(i[0]);
    send(43'h0C3_3C3C_1234, 0, 0, 0);
    #1 exp_up = 1; mask_up = 0;
    @(negedge clk); chk(up_err && payload === 43'h0C3_3C3C_1234, "R5 sync restart R1", 64'(payload), 64'h0C3_3C3C_1234);
    pulse_clr();
    send(43'h3FF_0000_0001, 1, 0, 1);
    @(negedge clk); chk(up_err, "R7 set wins over clear", 64'(up_err), 64'd1);
    pulse_clr();
    ticks(65);
    @(negedge clk); chk(adc_ok, "R9 before limit", 64'(adc_ok), 64'd1);
    ticks(1);
    @(negedge clk); chk(!adc_ok && link_ok, "R9 at limit", 64'({adc_ok, link_ok}), 64'd1);
    ticks(54);
    @(negedge clk); chk(!link_ok && payload === 43'd0, "R8 link down", 64'(link_ok), 64'd0);
    ticks(5);
    send(43'h001_2345_6789, 0, 0, 0);
    @(negedge clk); chk(link_ok && adc_ok, "R8 link back", 64'({link_ok, adc_ok}), 64'd3);
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule